// File: doc/BRIEF.md
# Load/Store Unit for a 16-bit RISC Core

This unit carries out the memory instructions of a small 16-bit RISC core. The core decodes the instruction, reads the register file and hands the unit a 5-bit opcode, the number of the data register, the 5-bit immediate field, up to two register values and the store data. The unit forms a 16-bit byte address, works out which byte lanes the access touches, and drives a request/ready bus to memory. For loads it returns the formatted result and the destination register number for write-back.

Addresses come in two forms. The first adds a sign-extended 5-bit immediate to a base register. The second adds two registers. Each form has word and byte variants for both loads and stores. Memory is little-endian. A word access at an odd address is refused and reported instead of being issued.

Top module: `lsu_mem_unit`

## Requirements
- R1: For opcodes 10000 to 10011, the address is `base_val` plus `imm_field` sign-extended to 16 bits, modulo 2^16. A negative immediate can wrap the address below 0x0000 to 0xFFFE.
- R2: For opcodes 10100 to 10111, the address is `base_val + idx_val` modulo 2^16, and `imm_field` has no effect on the access.
- R3: Opcode bit 0 selects store (1) or load (0), and bit 1 selects byte (1) or word (0). A start with an opcode whose upper two bits are not 10 issues no request and raises no `done`.
- R4: A word access drives `mem_be` = 11. A word store puts `store_val` unchanged on `mem_wdata`. A word load returns all 16 bits of `mem_rdata`.
- R5: A byte store drives `mem_be` = 01 at an even address and 10 at an odd address. It places `store_val[7:0]` in the enabled lane (bits 7:0 for the low lane, bits 15:8 for the high lane), so the other byte in memory is left unchanged.
- R6: A byte load returns `mem_rdata[7:0]` at an even address and `mem_rdata[15:8]` at an odd address, zero-extended to 16 bits.
- R7: A word access at an odd address issues no request and writes nothing. The following cycle it pulses `done` with `misaligned` = 1 and `load_wr` = 0.
- R8: Once `mem_req` rises, the address, write data, byte enables and write flag hold steady until `mem_ready` is seen. `done` is a one-cycle pulse in the cycle after that handshake.
- R9: On completion of a load, `load_wr` is 1 together with `done`, and `load_reg` equals the `dst_reg` given at start. On completion of a store, `load_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an access; taken only when idle |
| op_code | input | 5 | Instruction opcode field |
| dst_reg | input | 3 | Data register number (load destination) |
| imm_field | input | 5 | Low instruction bits: immediate, or ignored in register form |
| base_val | input | 16 | Base register value (R' or RA) |
| idx_val | input | 16 | Index register value (RB), register form only |
| store_val | input | 16 | Data register value for stores |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | 16 | Byte address |
| mem_be | output | 2 | Byte enables, bit 0 = low lane |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| mem_ready | input | 1 | Memory has completed the request |
| done | output | 1 | One-cycle completion pulse |
| misaligned | output | 1 | Completion was a refused odd word access |
| load_wr | output | 1 | Write-back valid for a load |
| load_reg | output | 3 | Write-back register number |
| load_data | output | 16 | Formatted load result |

## Verification
The tests use positive, negative and wrapping immediates. The wrap case shows whether the sign extension is truly 16 bits wide and not just a carry into the low bits. Register-form accesses run with a noisy immediate field to show that it is ignored. Byte stores go to both lanes over a preset neighbouring byte, and byte loads read a byte with its top bit set. Together these separate lane selection, replication and zero-extension faults. Odd word accesses, a non-memory opcode and a memory that stalls for several cycles test the refusal path, the decode guard and that the request holds steady.

// File: rtl/lsu_pkg.sv
// Shared types and opcode decode for the load/store unit.
// Assumes the memory opcode group is 10xxx with bit2 = register form,
// bit1 = byte size, bit0 = store.
package lsu_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } lsu_state_t;

    typedef struct packed {
        logic is_mem;
        logic reg_form;
        logic byte_sz;
        logic store;
    } mem_op_t;

    localparam logic [1:0] MEM_GROUP = 2'b10;

    function automatic mem_op_t decode_op(input logic [4:0] op);
        mem_op_t d;
        d.is_mem   = (op[4:3] == MEM_GROUP);
        d.reg_form = op[2];
        d.byte_sz  = op[1];
        d.store    = op[0];
        return d;
    endfunction

endpackage

// File: rtl/lsu_agen.sv
// Address generator: base plus sign-extended immediate, or base plus index.
// Assumes IMM_W < ADDR_W; the sum wraps modulo 2^ADDR_W.
module lsu_agen #(
    parameter int ADDR_W = 16,
    parameter int IMM_W  = 5
) (
    input  logic              reg_form,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] idx,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;

    // Pick the offset operand and add it to the base.
    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        addr    = base + (reg_form ? idx : imm_ext);
    end
endmodule

// File: rtl/lsu_lanes.sv
// Byte-lane steering for stores: byte enables and lane-replicated data.
// Assumes DATA_W is a whole number of bytes; lane 0 is the lowest address.
module lsu_lanes #(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8,
    parameter int OFS_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              byte_sz,
    input  logic [OFS_W-1:0]  lane,
    input  logic [DATA_W-1:0] sdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Enable every lane for a word, only the addressed lane for a byte.
        always_comb begin
            be[g]            = !byte_sz || (lane == OFS_W'(g));
            wdata[g*8 +: 8]  = byte_sz ? sdata[7:0] : sdata[g*8 +: 8];
        end
    end
endmodule

// File: rtl/lsu_ldfmt.sv
// Load formatter: passes a word through or zero-extends the addressed byte.
// Assumes little-endian lane order.
module lsu_ldfmt #(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8,
    parameter int OFS_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              byte_sz,
    input  logic [OFS_W-1:0]  lane,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [7:0] sel_byte;

    // Select the byte lane and widen it, or keep the full word.
    always_comb begin
        sel_byte = rdata[lane*8 +: 8];
        result   = byte_sz ? {{(DATA_W-8){1'b0}}, sel_byte} : rdata;
    end
endmodule

// File: rtl/lsu_mem_unit.sv
// Load/store unit top: accepts one access when idle, refuses odd word
// accesses, holds a request until ready, then pulses done with the
// formatted load result. Assumes the caller keeps start low while busy
// or accepts that such starts are dropped.
module lsu_mem_unit #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int IMM_W  = 5,
    parameter int REG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [4:0]        op_code,
    input  logic [REG_W-1:0]  dst_reg,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] idx_val,
    input  logic [DATA_W-1:0] store_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              done,
    output logic              misaligned,
    output logic              load_wr,
    output logic [REG_W-1:0]  load_reg,
    output logic [DATA_W-1:0] load_data
);
    import lsu_pkg::*;

    localparam int LANES = DATA_W / 8;
    localparam int OFS_W = (LANES > 1) ? $clog2(LANES) : 1;

    lsu_state_t        state_q;
    mem_op_t           dec;
    logic [ADDR_W-1:0] addr_c;
    logic [LANES-1:0]  be_c;
    logic [DATA_W-1:0] wdata_c;
    logic [OFS_W-1:0]  lane_c;
    logic              odd_word_c;
    logic              accept_c;

    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic              byte_q;
    logic [OFS_W-1:0]  lane_q;
    logic [REG_W-1:0]  reg_q;
    logic [DATA_W-1:0] fmt_c;

    // Decode the opcode and the low address bits of the incoming access.
    always_comb begin
        dec        = decode_op(op_code);
        lane_c     = addr_c[OFS_W-1:0];
        odd_word_c = !dec.byte_sz && (lane_c != '0);
        accept_c   = start && dec.is_mem && (state_q == ST_IDLE);
    end

    lsu_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
        .reg_form (dec.reg_form),
        .base     (base_val),
        .idx      (idx_val),
        .imm      (imm_field),
        .addr     (addr_c)
    );

    lsu_lanes #(.DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)) u_lanes (
        .byte_sz (dec.byte_sz),
        .lane    (lane_c),
        .sdata   (store_val),
        .be      (be_c),
        .wdata   (wdata_c)
    );

    lsu_ldfmt #(.DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)) u_ldfmt (
        .byte_sz (byte_q),
        .lane    (lane_q),
        .rdata   (mem_rdata),
        .result  (fmt_c)
    );

    // Sequence one access: launch, hold until ready, then report completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            be_q       <= '0;
            wdata_q    <= '0;
            we_q       <= 1'b0;
            byte_q     <= 1'b0;
            lane_q     <= '0;
            reg_q      <= '0;
            done       <= 1'b0;
            misaligned <= 1'b0;
            load_wr    <= 1'b0;
            load_reg   <= '0;
            load_data  <= '0;
        end else begin
            done       <= 1'b0;
            misaligned <= 1'b0;
            load_wr    <= 1'b0;
            if (accept_c) begin
                if (odd_word_c) begin
                    done       <= 1'b1;
                    misaligned <= 1'b1;
                end else begin
                    state_q <= ST_BUSY;
                    addr_q  <= addr_c;
                    be_q    <= be_c;
                    wdata_q <= wdata_c;
                    we_q    <= dec.store;
                    byte_q  <= dec.byte_sz;
                    lane_q  <= lane_c;
                    reg_q   <= dst_reg;
                end
            end else if (state_q == ST_BUSY && mem_ready) begin
                state_q   <= ST_IDLE;
                done      <= 1'b1;
                load_wr   <= !we_q;
                load_reg  <= reg_q;
                load_data <= we_q ? load_data : fmt_c;
            end
        end
    end

    // Present the held request on the bus while busy.
    always_comb begin
        mem_req   = (state_q == ST_BUSY);
        mem_we    = we_q && mem_req;
        mem_addr  = addr_q;
        mem_be    = mem_req ? be_q : '0;
        mem_wdata = wdata_q;
    end

    // R8: request fields hold until the memory answers.
    p_hold_until_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)
                                  && $stable(mem_be) && $stable(mem_we));

    // R8: a normal completion follows a handshake one cycle earlier.
    p_done_after_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !misaligned |-> $past(mem_req && mem_ready));

    // R7: a full-width request is never issued at an odd address.
    p_word_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && (&mem_be) |-> mem_addr[OFS_W-1:0] == '0);

    // R5: a byte request enables exactly the addressed lane.
    p_byte_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !(&mem_be) |-> $onehot(mem_be) && mem_be[mem_addr[OFS_W-1:0]]);

    // R9: write-back only with a clean completion.
    p_wb_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |-> done && !misaligned);

endmodule

// File: tb/lsu_mem_unit_tb.sv
// Directed bench for the load/store unit with a small byte memory model.
module lsu_mem_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  op_code = '0;
    logic [2:0]  dst_reg = '0;
    logic [4:0]  imm_field = '0;
    logic [15:0] base_val = '0, idx_val = '0, store_val = '0;
    logic        mem_req, mem_we, mem_ready;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, load_data;
    logic [1:0]  mem_be;
    logic        done, misaligned, load_wr;
    logic [2:0]  load_reg;

    int checks = 0, errors = 0;
    int wait_cycles = 0, wcnt = 0, req_count = 0, hold_err = 0, cyc = 0;
    logic [7:0]  bmem [0:255];
    logic        prev_pend = 1'b0;
    logic [15:0] prev_addr, prev_wdata;

    always #4 clk = ~clk;

    lsu_mem_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .dst_reg(dst_reg), .imm_field(imm_field), .base_val(base_val),
        .idx_val(idx_val), .store_val(store_val), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .done(done), .misaligned(misaligned), .load_wr(load_wr),
        .load_reg(load_reg), .load_data(load_data)
    );

    assign mem_rdata = {bmem[{mem_addr[7:1], 1'b1}], bmem[{mem_addr[7:1], 1'b0}]};

    // Memory model: ready after wait_cycles, writes on the handshake edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_ready <= 1'b0;
            wcnt <= 0;
        end else if (mem_req && !mem_ready) begin
            if (wcnt >= wait_cycles) mem_ready <= 1'b1;
            else wcnt <= wcnt + 1;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            wcnt <= 0;
            req_count <= req_count + 1;
            if (mem_req && mem_we) begin
                if (mem_be[0]) bmem[{mem_addr[7:1], 1'b0}] <= mem_wdata[7:0];
                if (mem_be[1]) bmem[{mem_addr[7:1], 1'b1}] <= mem_wdata[15:8];
            end
        end
        if (prev_pend && (mem_addr != prev_addr || mem_wdata != prev_wdata))
            hold_err <= hold_err + 1;
        prev_pend  <= mem_req && !mem_ready;
        prev_addr  <= mem_addr;
        prev_wdata <= mem_wdata;
    end

    initial begin
        mem_ready = 1'b0;
        for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    end

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue one access and wait for done, sampling at falling edges.
    task automatic run_op(input logic [4:0] op, input logic [2:0] rd,
                          input logic [4:0] imm, input logic [15:0] b,
                          input logic [15:0] ix, input logic [15:0] sd,
                          output bit got_done);
        int n = 0;
        @(negedge clk);
        op_code = op; dst_reg = rd; imm_field = imm;
        base_val = b; idx_val = ix; store_val = sd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        got_done = done;
    endtask

    task automatic t_reset();
        chk(!mem_req && !done && !misaligned && !load_wr, "reset idle R8",
            {12'h0, mem_req, done, misaligned, load_wr}, 16'h0);
    endtask

    task automatic t_imm_word();
        bit d;
        // R1 R4: store word at 0x20 + 4.
        run_op(5'b10001, 3'd1, 5'd4, 16'h0020, 16'h0, 16'hBEEF, d);
        chk(d && !load_wr, "R4 word store done, no write-back", {15'h0, load_wr}, 16'h0);
        chk({bmem[8'h25], bmem[8'h24]} == 16'hBEEF, "R1 R4 word store at 0x24",
            {bmem[8'h25], bmem[8'h24]}, 16'hBEEF);
        // R1 negative immediate: 0x26 + (-2) = 0x24.
        run_op(5'b10000, 3'd5, 5'b11110, 16'h0026, 16'h0, 16'h0, d);
        chk(d && load_data == 16'hBEEF, "R1 R4 word load with negative imm",
            load_data, 16'hBEEF);
        chk(load_wr && load_reg == 3'd5, "R9 load write-back reg", {13'h0, load_reg}, 16'd5);
        @(negedge clk);
        chk(!done, "R8 done is a single pulse", {15'h0, done}, 16'h0);
    endtask

    task automatic t_wrap();
        bit d;
        // R1: 0x0002 + (-4) wraps to 0xFFFE (model index 0xFE).
        run_op(5'b10001, 3'd2, 5'b11100, 16'h0002, 16'h0, 16'h1357, d);
        chk({bmem[8'hFF], bmem[8'hFE]} == 16'h1357, "R1 wrap store to 0xFFFE",
            {bmem[8'hFF], bmem[8'hFE]}, 16'h1357);
        bmem[8'h02] = 8'h00; bmem[8'h03] = 8'h00;
        run_op(5'b10000, 3'd3, 5'b11111, 16'hFFFF, 16'h0, 16'h0, d);
        chk(load_data == 16'h1357, "R1 wrap load 0xFFFF-1", load_data, 16'h1357);
    endtask

    task automatic t_byte_store();
        bit d;
        bmem[8'h40] = 8'h5A; bmem[8'h41] = 8'h00;
        // R2 R5: 0x30 + 0x11 = 0x41 (odd, high lane), imm field noise.
        run_op(5'b10111, 3'd1, 5'b10111, 16'h0030, 16'h0011, 16'h12A5, d);
        chk(bmem[8'h41] == 8'hA5, "R5 byte store high lane", {8'h0, bmem[8'h41]}, 16'h00A5);
        chk(bmem[8'h40] == 8'h5A, "R5 neighbour lane untouched", {8'h0, bmem[8'h40]}, 16'h005A);
        // R5 even lane via immediate form.
        bmem[8'h51] = 8'h77;
        run_op(5'b10011, 3'd1, 5'd0, 16'h0050, 16'h0, 16'hFFC3, d);
        chk({bmem[8'h51], bmem[8'h50]} == 16'h77C3, "R5 byte store low lane",
            {bmem[8'h51], bmem[8'h50]}, 16'h77C3);
    endtask

    task automatic t_byte_load();
        bit d;
        bmem[8'h60] = 8'h3C; bmem[8'h61] = 8'hE1;
        // R2 R6: 0x5F + 0x02 = 0x61, imm field set to 11111 (ignored).
        run_op(5'b10110, 3'd4, 5'b11111, 16'h005F, 16'h0002, 16'h0, d);
        chk(load_data == 16'h00E1, "R6 byte load odd zero-extended", load_data, 16'h00E1);
        chk(load_reg == 3'd4 && load_wr, "R9 byte load reg", {13'h0, load_reg}, 16'd4);
        run_op(5'b10010, 3'd6, 5'd0, 16'h0060, 16'h0, 16'h0, d);
        chk(load_data == 16'h003C, "R6 byte load even", load_data, 16'h003C);
        // R2 register-form word load with imm noise.
        run_op(5'b10100, 3'd2, 5'b01010, 16'h0020, 16'h0004, 16'h0, d);
        chk(load_data == 16'hBEEF, "R2 reg-form word load", load_data, 16'hBEEF);
    endtask

    task automatic t_misaligned();
        bit d;
        int rc;
        bmem[8'h70] = 8'h11; bmem[8'h71] = 8'h22; bmem[8'h72] = 8'h33;
        rc = req_count;
        run_op(5'b10001, 3'd1, 5'd1, 16'h0070, 16'h0, 16'hDEAD, d);
        chk(d && misaligned, "R7 odd word store flagged", {15'h0, misaligned}, 16'h1);
        chk({bmem[8'h72], bmem[8'h71], bmem[8'h70]} == 24'h332211 && req_count == rc,
            "R7 no write and no request", {bmem[8'h71], bmem[8'h70]}, 16'h2211);
        run_op(5'b10100, 3'd3, 5'd0, 16'h0070, 16'h0003, 16'h0, d);
        chk(d && misaligned && !load_wr, "R7 odd word load no write-back",
            {14'h0, misaligned, load_wr}, 16'h2);
    endtask

    task automatic t_not_mem();
        int rc;
        bit seen = 0;
        rc = req_count;
        @(negedge clk);
        op_code = 5'b00110; base_val = 16'h0020; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (done || mem_req) seen = 1;
            @(negedge clk);
        end
        chk(!seen && req_count == rc, "R3 non-memory opcode ignored", {15'h0, seen}, 16'h0);
    endtask

    task automatic t_stall();
        bit d;
        wait_cycles = 5;
        run_op(5'b10101, 3'd1, 5'd3, 16'h0080, 16'h0002, 16'hCAFE, d);
        chk(d && {bmem[8'h83], bmem[8'h82]} == 16'hCAFE, "R8 store with wait states",
            {bmem[8'h83], bmem[8'h82]}, 16'hCAFE);
        run_op(5'b10000, 3'd7, 5'd2, 16'h0080, 16'h0, 16'h0, d);
        chk(d && load_data == 16'hCAFE, "R8 load with wait states", load_data, 16'hCAFE);
        chk(hold_err == 0, "R8 request held stable", hold_err[15:0], 16'h0);
        wait_cycles = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_imm_word();
        t_wrap();
        t_byte_store();
        t_byte_load();
        t_misaligned();
        t_not_mem();
        t_stall();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cyc > 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule